// File: doc/BRIEF.md
# Serial Link Transmit Start-up Sequencer

This block is the transmit link start-up controller for a group of serial converter lanes. It watches the receiver's active-low synchronisation request (`sync_n`) and a strobe that marks the first link-clock slot of each multiframe (`mf_start`). On every link clock it drives, for each lane, a 32-bit word of four octets and four per-octet control (K) flags. The 8b/10b encoder, the serializer, the scrambler and the transport sample mapping sit outside this block.

While the receiver asks for synchronisation, the lanes carry only comma characters. When the request is released, the block waits for the next multiframe boundary. On that boundary it sends a four-multiframe alignment sequence. Each of these multiframes is framed by start and end markers, and the second one carries the link configuration octets of the lane. The cycle after the sequence ends, the lanes carry user data. A phase output and a one-clock pulse on entry to user data let the surrounding logic follow the bring-up.

All outputs are registered and lag the inputs that decide them by one link clock. A multiframe holds `MF_OCTETS` octets per lane, which must be a multiple of 4 and at least 20.

Top module: `jtx_link_startup`

## Requirements
- R1: When `sync_n` is sampled low, every octet of every lane on the next clock is 0xBC with its K flag set.
- R2: After `sync_n` returns high, comma octets continue until a clock in which `mf_start` is sampled high. The word on the following clock is the first alignment word.
- R3: The alignment phase (`link_phase` = 1) lasts exactly 4*MF_OCTETS/4 clocks when it is not interrupted.
- R4: In each alignment multiframe, octet position 0 is 0x1C and the last position (MF_OCTETS-1) is 0x7C, both with the K flag set. These are the only K octets apart from the one in R5, so each lane sends 9 K octets per alignment sequence.
- R5: In the second alignment multiframe, position 1 is 0x9C with the K flag set. Positions 2 to 15 carry configuration octets 0 to 13 of that lane, with the K flag clear. For lane l, octet j is taken from `cfg_octets[112*l + 8*j +: 8]`.
- R6: Every other alignment octet carries its position within the multiframe (0..MF_OCTETS-1) as its value, with the K flag clear.
- R7: The clock after the last alignment word, each lane carries the `tx_user` word sampled one clock earlier, with all K flags clear. There is no gap between the two phases.
- R8: A low `sync_n` in the alignment or data phase returns `link_phase` to 0 and the lanes to commas on the next clock.
- R9: `link_phase` reports the phase of the word currently driven: 0 for synchronisation, 1 for alignment, 2 for data. `data_start` is high for exactly the one clock that carries the first data word after an alignment sequence.
- R10: Octet b of lane l sits at bits [32*l + 8*b +: 8] of `lane_data`, and its flag at bit 4*l + b of `lane_isk`. Octet 0 is the earliest in time.
- R11: While `rst_n` is low, the lanes carry commas with all flags set, `link_phase` is 0 and `data_start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Receiver synchronisation request, active low |
| mf_start | input | 1 | High in the link clock slot that opens a multiframe |
| cfg_octets | input | LANES*112 | Fourteen configuration octets per lane |
| tx_user | input | LANES*32 | User data words, one per lane |
| lane_data | output | LANES*32 | Four octets per lane per clock |
| lane_isk | output | LANES*4 | K flag per octet |
| link_phase | output | 2 | Phase of the current output word |
| data_start | output | 1 | One-clock pulse with the first data word |

## Verification
The bench builds the block with LANES=2 and MF_OCTETS=20. With these values a multiframe is five words long, so it is not a power of two. The end marker falls in octet 3 of the fifth word, and the configuration block runs across word boundaries into the ramp octets 16 to 18. Two lanes with different configuration slices expose lane or octet swaps. The short multiframe also lets hundreds of random request drops land in every phase, including inside the alignment sequence and one clock before its end.

// File: rtl/jtx_pkg.sv
package jtx_pkg;

  typedef enum logic [1:0] {
    PH_CGS  = 2'd0,
    PH_ILAS = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  localparam logic [7:0] K_COMMA  = 8'hBC;
  localparam logic [7:0] K_RSTART = 8'h1C;
  localparam logic [7:0] K_ALIGN  = 8'h7C;
  localparam logic [7:0] K_QCFG   = 8'h9C;
  localparam int CFG_OCTETS = 14;
  localparam int CFG_BITS   = 8 * CFG_OCTETS;
  localparam int CFG_FIRST  = 2;

  typedef struct packed {
    logic [7:0] val;
    logic       isk;
  } octet_t;

  // Octet n (counted from the start of the alignment sequence) of one lane.
  function automatic octet_t ilas_octet(input int unsigned n,
                                        input int unsigned mfo,
                                        input logic [CFG_BITS-1:0] cfg);
    int unsigned mf;
    int unsigned pos;
    octet_t o;
    mf    = n / mfo;
    pos   = n % mfo;
    o.val = 8'(pos);
    o.isk = 1'b0;
    if (pos == 0) begin
      o.val = K_RSTART;
      o.isk = 1'b1;
    end else if (pos == mfo - 1) begin
      o.val = K_ALIGN;
      o.isk = 1'b1;
    end else if (mf == 1 && pos == 1) begin
      o.val = K_QCFG;
      o.isk = 1'b1;
    end else if (mf == 1 && pos >= CFG_FIRST && pos < CFG_FIRST + CFG_OCTETS) begin
      o.val = cfg[8*(pos-CFG_FIRST) +: 8];
    end
    return o;
  endfunction

endpackage

// File: rtl/jtx_phase_seq.sv
module jtx_phase_seq
  import jtx_pkg::*;
#(
  parameter int ILAS_WORDS = 32,
  localparam int IDX_W = $clog2(ILAS_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_n,
  input  logic             mf_start,
  output phase_e           nxt_phase,
  output logic [IDX_W-1:0] nxt_idx,
  output phase_e           phase_q,
  output logic             data_start_q
);

  logic [IDX_W-1:0] idx_q;
  logic             ilas_last;
  logic             enter_data;

  assign ilas_last  = (phase_q == PH_ILAS) && (idx_q == IDX_W'(ILAS_WORDS - 1));
  assign enter_data = (phase_q == PH_ILAS) && (nxt_phase == PH_DATA);

  always_comb begin
    nxt_phase = phase_q;
    nxt_idx   = idx_q;
    if (!sync_n) begin
      nxt_phase = PH_CGS;
      nxt_idx   = '0;
    end else begin
      unique case (phase_q)
        PH_CGS: begin
          if (mf_start) begin
            nxt_phase = PH_ILAS;
            nxt_idx   = '0;
          end
        end
        PH_ILAS: begin
          if (ilas_last) nxt_phase = PH_DATA;
          else           nxt_idx   = idx_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_CGS;
      idx_q        <= '0;
      data_start_q <= 1'b0;
    end else begin
      phase_q      <= nxt_phase;
      idx_q        <= nxt_idx;
      data_start_q <= enter_data;
    end
  end

  a_r8_back_to_cgs: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> phase_q == PH_CGS);

  a_r2_wait_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CGS && !mf_start) |=> phase_q == PH_CGS);

  a_r2_start_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CGS && sync_n && mf_start) |=> (phase_q == PH_ILAS && idx_q == '0));

  a_r9_pulse_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    data_start_q |-> (phase_q == PH_DATA && $past(phase_q) == PH_ILAS));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    data_start_q |=> !data_start_q);

endmodule

// File: rtl/jtx_lane_mux.sv
module jtx_lane_mux
  import jtx_pkg::*;
#(
  parameter int MF_OCTETS = 32,
  parameter int IDX_W     = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  phase_e              sel_phase,
  input  logic [IDX_W-1:0]    word_idx,
  input  logic [CFG_BITS-1:0] cfg,
  input  logic [31:0]         user,
  output logic [31:0]         data_q,
  output logic [3:0]          isk_q
);

  logic [7:0] nxt_val [4];
  logic       nxt_k   [4];

  for (genvar b = 0; b < 4; b++) begin : g_oct
    octet_t ilas_o;
    assign ilas_o     = ilas_octet(32'(word_idx) * 4 + b, MF_OCTETS, cfg);
    assign nxt_val[b] = (sel_phase == PH_CGS)  ? K_COMMA    :
                        (sel_phase == PH_ILAS) ? ilas_o.val : user[8*b +: 8];
    assign nxt_k[b]   = (sel_phase == PH_CGS) || ((sel_phase == PH_ILAS) && ilas_o.isk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= {4{K_COMMA}};
      isk_q  <= 4'hF;
    end else begin
      for (int b = 0; b < 4; b++) begin
        data_q[8*b +: 8] <= nxt_val[b];
        isk_q[b]         <= nxt_k[b];
      end
    end
  end

  a_r7_user_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sel_phase == PH_DATA |=> (isk_q == 4'h0 && data_q == $past(user)));

endmodule

// File: rtl/jtx_link_startup.sv
module jtx_link_startup
  import jtx_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int MF_OCTETS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_n,
  input  logic                    mf_start,
  input  logic [LANES*112-1:0]    cfg_octets,
  input  logic [LANES*32-1:0]     tx_user,
  output logic [LANES*32-1:0]     lane_data,
  output logic [LANES*4-1:0]      lane_isk,
  output logic [1:0]              link_phase,
  output logic                    data_start
);

  localparam int MF_WORDS   = MF_OCTETS / 4;
  localparam int ILAS_WORDS = 4 * MF_WORDS;
  localparam int IDX_W      = $clog2(ILAS_WORDS);

  phase_e           nxt_phase;
  phase_e           phase_q;
  logic [IDX_W-1:0] nxt_idx;

  jtx_phase_seq #(.ILAS_WORDS(ILAS_WORDS)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_n       (sync_n),
    .mf_start     (mf_start),
    .nxt_phase    (nxt_phase),
    .nxt_idx      (nxt_idx),
    .phase_q      (phase_q),
    .data_start_q (data_start)
  );

  assign link_phase = phase_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    jtx_lane_mux #(.MF_OCTETS(MF_OCTETS), .IDX_W(IDX_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_phase (nxt_phase),
      .word_idx  (nxt_idx),
      .cfg       (cfg_octets[CFG_BITS*l +: CFG_BITS]),
      .user      (tx_user[32*l +: 32]),
      .data_q    (lane_data[32*l +: 32]),
      .isk_q     (lane_isk[4*l +: 4])
    );
  end

  a_r1_comma_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> (lane_data == {(LANES*4){K_COMMA}} && (&lane_isk)));

  a_r4_first_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (link_phase == 2'd1 && $past(link_phase) == 2'd0) |-> (lane_data[7:0] == K_RSTART && lane_isk[0]));

  a_r7_data_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    link_phase == 2'd2 |-> lane_isk == '0);

  a_r9_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    link_phase != 2'd3);

endmodule

// File: tb/sim_jtx_link_startup.sv
module sim_jtx_link_startup;

  localparam int LANES = 2;
  localparam int MFO   = 20;
  localparam int MFW   = MFO / 4;
  localparam int IW    = 4 * MFW;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 sync_n = 1'b0;
  logic                 mf_start = 1'b0;
  logic [LANES*112-1:0] cfg_octets = '0;
  logic [LANES*32-1:0]  tx_user = '0;
  logic [LANES*32-1:0]  lane_data;
  logic [LANES*4-1:0]   lane_isk;
  logic [1:0]           link_phase;
  logic                 data_start;

  jtx_link_startup #(.LANES(LANES), .MF_OCTETS(MFO)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .mf_start(mf_start),
    .cfg_octets(cfg_octets), .tx_user(tx_user), .lane_data(lane_data),
    .lane_isk(lane_isk), .link_phase(link_phase), .data_start(data_start)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // bench model state
  int   mph = 0;
  int   midx = 0;
  int   mfc = 0;
  int   e_ph = 0;
  int   e_prev = 0;
  int   e_idx = 0;
  bit   e_sync = 1'b0;
  bit   e_pulse = 1'b0;
  logic [7:0] e_val [LANES][4];
  logic       e_k   [LANES][4];
  logic [31:0] e_user [LANES];
  int   ilas_len = 0;
  int   kcount [LANES];

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [8:0] ref_octet(input int l, input int n);
    int pos = n;
    int mf  = 0;
    while (pos >= MFO) begin
      pos -= MFO;
      mf++;
    end
    if (pos == MFO - 1) return {1'b1, 8'h7C};
    if (pos == 0)       return {1'b1, 8'h1C};
    if (mf == 1 && pos == 1) return {1'b1, 8'h9C};
    if (mf == 1 && pos <= 15) return {1'b0, cfg_octets[112*l + 8*(pos-2) +: 8]};
    return {1'b0, 8'(pos)};
  endfunction

  function automatic string ref_tag(input int n);
    int pos = n % MFO;
    if (pos == 0 || pos == MFO - 1) return "R4";
    if ((n / MFO) == 1 && pos <= 15) return "R5";
    return "R6";
  endfunction

  task automatic step_model();
    int nph = mph;
    int nidx = midx;
    if (!sync_n) begin
      nph = 0; nidx = 0;
    end else if (mph == 0) begin
      if (mf_start) begin nph = 1; nidx = 0; end
    end else if (mph == 1) begin
      if (midx == IW - 1) nph = 2;
      else nidx = midx + 1;
    end
    e_pulse = (mph == 1 && nph == 2);
    e_prev  = mph;
    e_ph    = nph;
    e_idx   = nidx;
    e_sync  = sync_n;
    for (int l = 0; l < LANES; l++) begin
      e_user[l] = tx_user[32*l +: 32];
      for (int b = 0; b < 4; b++) begin
        if (nph == 0) begin
          e_val[l][b] = 8'hBC; e_k[l][b] = 1'b1;
        end else if (nph == 1) begin
          {e_k[l][b], e_val[l][b]} = ref_octet(l, nidx * 4 + b);
        end else begin
          e_val[l][b] = tx_user[32*l + 8*b +: 8]; e_k[l][b] = 1'b0;
        end
      end
    end
    mph  = nph;
    midx = nidx;
  endtask

  task automatic compare_all();
    string tag;
    tag = (e_ph != 0) ? "R9" : ((!e_sync && e_prev != 0) ? "R8" : "R9");
    chk(tag, "link_phase", 32'(link_phase), 32'(e_ph));
    chk("R9", "data_start", 32'(data_start), 32'(e_pulse));
    if (e_ph == 1 && e_prev != 1) begin
      ilas_len = 0;
      for (int l = 0; l < LANES; l++) kcount[l] = 0;
    end
    if (e_pulse) begin
      chk("R3", "alignment length", 32'(ilas_len), 32'(IW));
      for (int l = 0; l < LANES; l++)
        chk("R4", $sformatf("K octet count lane %0d", l), 32'(kcount[l]), 32'd9);
    end
    for (int l = 0; l < LANES; l++) begin
      for (int b = 0; b < 4; b++) begin
        if (e_ph == 0)      tag = !e_sync ? ((e_prev != 0) ? "R8" : "R1") : "R2";
        else if (e_ph == 1) tag = ref_tag(e_idx * 4 + b);
        else                tag = "R7";
        chk(tag, $sformatf("lane %0d octet %0d {k,val}", l, b),
            32'({lane_isk[4*l + b], lane_data[32*l + 8*b +: 8]}),
            32'({e_k[l][b], e_val[l][b]}));
      end
      if (e_ph == 2)
        chk("R10", $sformatf("lane %0d word order", l), lane_data[32*l +: 32], e_user[l]);
      if (e_ph == 1) kcount[l] += $countones(lane_isk[4*l +: 4]);
    end
    if (e_ph == 1) ilas_len++;
  endtask

  task automatic cycle(input bit s);
    @(negedge clk);
    compare_all();
    sync_n   = s;
    mfc      = (mfc + 1) % MFW;
    mf_start = (mfc == 0);
    tx_user  = {$urandom, $urandom};
    step_model();
  endtask

  bit done = 1'b0;
  int seed_v;

  initial begin
    seed_v = $urandom(32'd1234);
    for (int l = 0; l < LANES; l++) kcount[l] = 0;
    for (int l = 0; l < LANES; l++) begin
      e_user[l] = '0;
      for (int b = 0; b < 4; b++) begin e_val[l][b] = 8'hBC; e_k[l][b] = 1'b1; end
    end
    for (int i = 0; i < LANES * 4; i++) cfg_octets[32*i +: 32] = $urandom;
    // R11: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R11", "reset lane_data", lane_data[31:0], 32'hBCBCBCBC);
      chk("R11", "reset lane_isk", 32'(lane_isk), 32'(8'hFF));
      chk("R11", "reset phase", 32'(link_phase), 32'd0);
      chk("R11", "reset pulse", 32'(data_start), 32'd0);
    end
    rst_n = 1'b1;
    // directed: request held, release mid-multiframe, full bring-up
    repeat (7) cycle(1'b0);
    while (mfc != 2) cycle(1'b0);
    repeat (IW + 3 * MFW) cycle(1'b1);
    // directed: one-clock drop in data phase
    cycle(1'b0);
    repeat (IW - 1 + 2 * MFW) cycle(1'b1);
    // directed: drop one clock before alignment ends
    cycle(1'b0);
    while (mph != 1 || midx != IW - 2) cycle(1'b1);
    cycle(1'b0);
    repeat (3 * IW) cycle(1'b1);
    // random mix
    for (int seg = 0; seg < 300; seg++) begin
      int lo = 1 + ($urandom % 4);
      int hi = 3 + ($urandom % 60);
      if ($urandom % 8 == 0) cfg_octets[32*($urandom % (LANES*3)) +: 32] = $urandom;
      repeat (lo) cycle(1'b0);
      repeat (hi) cycle(1'b1);
    end
    cycle(1'b1);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule